// File: doc/BRIEF.md
# Die-to-Die Link Transaction Initiator

This block sits on a 16-bit CPU bus and turns loads and stores that land in one of two 256-byte address windows into transactions on a die-to-die link. A store starts a link write and a load starts a link read. The link address is the byte offset inside the window. A byte access moves 8 bits, and a 16-bit access moves a whole word. One window gives blocking behaviour: the CPU is held in wait-states until the target answers. The other window is non-blocking: the access retires at once, and software collects a read result later from the data buffer.

A small register page holds the link configuration: a clock divider, a lane-width code, the timeout and an enable bit. Once the enable bit is set, software cannot clear it. The page also holds a status byte, an address buffer and a data buffer. Only one link transaction runs at a time, and a window access made while one is pending stalls the CPU. If the target does not answer within the programmed number of cycles, the block withdraws the request and sets a sticky error bit. A blocking read that times out returns zero. The target side is a plain request/acknowledge handshake.

Top module: `die_link_initiator`

## Requirements
- R1: After reset all configuration, status and buffer bytes read as zero, `linkReq` is low and `cpuWait` is low.
- R2: While the enable bit is clear, window accesses are ignored. No request is raised, `cpuWait` stays low and a window read returns zero.
- R3: Register page offsets from the page base are: 0 = {enable bit 7, lane code bits 5:4, divider bits 3:0}; 1 = timeout; 2 = status {busy bit 1, error bit 0}; 4 = {write bit 7, wide bit 6}; 5 = window offset; 6/7 = data buffer high/low. A byte write updates one byte. A 16-bit write at offset 0 updates offset 0 from data bits 15:8 and offset 1 from data bits 7:0. A 16-bit read at an even offset returns that byte in bits 15:8 and the next byte in bits 7:0. A byte read returns the byte zero-extended. The divider and lane code also drive `linkDiv` and `linkLanes`.
- R4: The enable bit is write-once. Writing it as 0 after it has been set leaves it set until reset.
- R5: A window store starts a link write with `linkWr` high and the window offset on `linkAddr`. A byte store sends its data in bits 7:0 with bits 15:8 at zero. A window load starts a link read.
- R6: Only one transaction is active at a time. A window access that arrives while a transaction is pending is stalled with `cpuWait` until the earlier transaction is over, and only then is it started.
- R7: A blocking access (window base 0x0400) holds `cpuWait` until the target acknowledges. A blocking load then returns the target's read data: all 16 bits for a wide load, or bits 7:0 zero-extended for a byte load.
- R8: A non-blocking access (window base 0x0500) started while idle completes with no wait-state. The result of a read is later found in the data buffer.
- R9: A 16-bit transfer is big-endian. `linkWide` is high, the given offset carries data bits 15:8 and the next offset carries bits 7:0. The data buffer shows bits 15:8 at offset 6.
- R10: With timeout T, a transaction not acknowledged by its (T+1)-th busy cycle is aborted. The request drops, the sticky error bit sets, and a blocking access sees exactly T+2 wait-states. An acknowledge in that last cycle counts as success.
- R11: A read that times out leaves zero in the data buffer, and a blocking read that times out returns zero to the CPU.
- R12: The address buffer records the window offset, the direction and the width of the most recent transaction.
- R13: The data buffer holds the write data from the start of a write, while the transaction is still pending. For a read it holds the target's data once the acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | CPU access valid; held while `cpuWait` is high |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuWide | input | 1 | 1 = 16-bit access, 0 = byte access |
| cpuAddr | input | 16 | CPU byte address |
| cpuWdata | input | 16 | Store data; a byte store uses bits 7:0 |
| cpuRdata | output | 16 | Load data, valid in the cycle `cpuWait` is low |
| cpuWait | output | 1 | Wait-state request to the CPU |
| linkReq | output | 1 | Transaction request to the target |
| linkWr | output | 1 | Request direction, 1 = write |
| linkWide | output | 1 | Request width, 1 = 16 bits |
| linkAddr | output | 8 | Window offset of the request |
| linkWdata | output | 16 | Write data of the request |
| linkAck | input | 1 | Target acknowledge, one cycle |
| linkRdata | input | 16 | Target read data, valid with `linkAck` |
| linkDiv | output | 4 | Configured link clock divider |
| linkLanes | output | 2 | Configured link lane-width code |

## Verification
Two events can fall in the same cycle: the target's acknowledge and the last cycle of the timeout window. To provoke this, the bench target holds its acknowledge back exactly as many cycles as the programmed timeout, so the acknowledge lands in the busy cycle where the counter reaches its limit. The outcome is judged at the ports. The blocking load must return the target's data with T+2 wait-states, and the error bit must stay clear. A second kind of overlap is a new window access while a non-blocking transaction is still pending. It is checked by the wait-states and data the stalled load sees.

// File: rtl/die_link_pkg.sv
package die_link_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } linkState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;   // latch a new transaction from the CPU bus
    logic track;   // a transaction is in flight this cycle
    logic finish;  // target acknowledged this cycle
    logic abort;   // timeout reached without acknowledge
  } linkStrobe_t;

  localparam int REG_BYTES = 8;
  localparam int REG_OFF_W = $clog2(REG_BYTES);
  localparam int WIN_OFF_W = 8;

endpackage

// File: rtl/die_link_ctrl.sv
module die_link_ctrl
  import die_link_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int TMO_W  = 8,
  parameter logic [PAGE_W-1:0] BLK_PAGE = 8'h04,
  parameter logic [PAGE_W-1:0] NBK_PAGE = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic [PAGE_W-1:0] cpuPage,
  input  logic              enable,
  input  logic [TMO_W-1:0]  tmoVal,
  input  logic              linkAck,
  output logic              cpuWait,
  output linkStrobe_t       strb,
  output logic              busy,
  output logic              retire
);

  linkState_t       state;
  logic [TMO_W-1:0] cnt;
  logic             isBlk;
  logic             blkHit, nbkHit, winAcc;

  always_comb begin
    blkHit = (cpuPage == BLK_PAGE);
    nbkHit = (cpuPage == NBK_PAGE);
    winAcc = cpuSel && enable && (blkHit || nbkHit);
  end

  always_comb begin
    strb        = '0;
    strb.start  = winAcc && (state == ST_IDLE);
    strb.track  = (state == ST_BUSY);
    strb.finish = strb.track && linkAck;
    strb.abort  = strb.track && !linkAck && (cnt >= tmoVal);
  end

  // blocking access waits from its first cycle; anything waits while busy
  always_comb begin
    cpuWait = winAcc && ((state == ST_BUSY) || ((state == ST_IDLE) && blkHit));
    busy    = (state != ST_IDLE);
    retire  = (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isBlk <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.start) begin
            state <= ST_BUSY;
            cnt   <= '0;
            isBlk <= blkHit;
          end
        end
        ST_BUSY: begin
          if (strb.finish || strb.abort) begin
            state <= isBlk ? ST_DONE : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a non-blocking access from idle is never stretched
  a_r8_nb_no_wait: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && nbkHit && enable && (state == ST_IDLE)) |-> !cpuWait);

  // R7: the retire cycle is always followed by idle
  a_r7_retire_once: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/die_link_datapath.sv
module die_link_datapath
  import die_link_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4,
  parameter int LANE_W = 2,
  parameter int TMO_W  = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h0080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic              cpuWide,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  linkStrobe_t       strb,
  input  logic              busy,
  input  logic              retire,
  output logic              enable,
  output logic [TMO_W-1:0]  tmoVal,
  output logic              linkReq,
  output logic              linkWr,
  output logic              linkWide,
  output logic [WIN_OFF_W-1:0] linkAddr,
  output logic [DATA_W-1:0] linkWdata,
  input  logic [DATA_W-1:0] linkRdata,
  output logic [DIV_W-1:0]  linkDiv,
  output logic [LANE_W-1:0] linkLanes
);

  localparam int HALF_W = DATA_W / 2;

  logic                 regHit;
  logic [REG_OFF_W-1:0] regOff;
  logic                 wrA, wrB;
  logic [7:0]           valA, valB;
  logic                 errFlag;
  logic                 abWr, abWide;
  logic [WIN_OFF_W-1:0] abOff;
  logic [DATA_W-1:0]    dataBuf;
  logic [DATA_W-1:0]    rdMasked;
  logic [7:0]           regBytes [REG_BYTES];

  always_comb begin
    regHit = cpuSel && (cpuAddr[ADDR_W-1:REG_OFF_W] == REG_BASE[ADDR_W-1:REG_OFF_W]);
    regOff = cpuAddr[REG_OFF_W-1:0];
  end

  // configuration write decode: wide writes fill a big-endian byte pair
  always_comb begin
    wrA  = 1'b0;
    wrB  = 1'b0;
    valA = cpuWdata[7:0];
    valB = cpuWdata[7:0];
    if (regHit && cpuWe) begin
      if (cpuWide) begin
        if (regOff[REG_OFF_W-1:1] == '0) begin
          wrA  = 1'b1;
          wrB  = 1'b1;
          valA = cpuWdata[DATA_W-1:HALF_W];
        end
      end else begin
        wrA = (regOff == REG_OFF_W'(0));
        wrB = (regOff == REG_OFF_W'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable    <= 1'b0;
      linkDiv   <= '0;
      linkLanes <= '0;
      tmoVal    <= '0;
    end else begin
      if (wrA) begin
        enable    <= enable | valA[7];
        linkLanes <= valA[4 +: LANE_W];
        linkDiv   <= valA[0 +: DIV_W];
      end
      if (wrB) tmoVal <= valB[TMO_W-1:0];
    end
  end

  always_comb begin
    rdMasked = linkWide ? linkRdata : {{HALF_W{1'b0}}, linkRdata[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkReq   <= 1'b0;
      linkWr    <= 1'b0;
      linkWide  <= 1'b0;
      linkAddr  <= '0;
      linkWdata <= '0;
      errFlag   <= 1'b0;
      abWr      <= 1'b0;
      abWide    <= 1'b0;
      abOff     <= '0;
      dataBuf   <= '0;
    end else begin
      if (strb.start) begin
        linkReq   <= 1'b1;
        linkWr    <= cpuWe;
        linkWide  <= cpuWide;
        linkAddr  <= cpuAddr[WIN_OFF_W-1:0];
        linkWdata <= cpuWide ? cpuWdata : {{HALF_W{1'b0}}, cpuWdata[HALF_W-1:0]};
        abWr      <= cpuWe;
        abWide    <= cpuWide;
        abOff     <= cpuAddr[WIN_OFF_W-1:0];
        if (cpuWe) dataBuf <= cpuWide ? cpuWdata : {{HALF_W{1'b0}}, cpuWdata[HALF_W-1:0]};
        else       dataBuf <= '0;
      end
      if (strb.track && !linkWr) dataBuf <= rdMasked;
      if (strb.finish) linkReq <= 1'b0;
      if (strb.abort) begin
        linkReq <= 1'b0;
        errFlag <= 1'b1;
        if (!linkWr) dataBuf <= '0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < REG_BYTES; i++) regBytes[i] = '0;
    regBytes[0][7]          = enable;
    regBytes[0][4 +: LANE_W] = linkLanes;
    regBytes[0][0 +: DIV_W]  = linkDiv;
    regBytes[1][TMO_W-1:0]  = tmoVal;
    regBytes[2]             = {6'b0, busy, errFlag};
    regBytes[4]             = {abWr, abWide, 6'b0};
    regBytes[5]             = abOff;
    regBytes[6]             = dataBuf[DATA_W-1:HALF_W];
    regBytes[7]             = dataBuf[HALF_W-1:0];
  end

  always_comb begin
    cpuRdata = '0;
    if (regHit && !cpuWe) begin
      if (cpuWide) cpuRdata = {regBytes[{regOff[REG_OFF_W-1:1], 1'b0}],
                               regBytes[{regOff[REG_OFF_W-1:1], 1'b1}]};
      else         cpuRdata = {8'h00, regBytes[regOff]};
    end else if (retire && cpuSel && !cpuWe) begin
      cpuRdata = dataBuf;
    end
  end

  a_r4_enable_sticky: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> enable);

  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !linkReq) |=> !linkReq);

  a_r6_single_active: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |-> !linkReq);

endmodule

// File: rtl/die_link_initiator.sv
module die_link_initiator
  import die_link_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4,
  parameter int LANE_W = 2,
  parameter int TMO_W  = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h0080,
  parameter logic [ADDR_W-1:0] BLK_BASE = 16'h0400,
  parameter logic [ADDR_W-1:0] NBK_BASE = 16'h0500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic              cpuWide,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuWait,
  output logic              linkReq,
  output logic              linkWr,
  output logic              linkWide,
  output logic [7:0]        linkAddr,
  output logic [DATA_W-1:0] linkWdata,
  input  logic              linkAck,
  input  logic [DATA_W-1:0] linkRdata,
  output logic [DIV_W-1:0]  linkDiv,
  output logic [LANE_W-1:0] linkLanes
);

  localparam int PAGE_W = ADDR_W - WIN_OFF_W;
  localparam logic [PAGE_W-1:0] BLK_PAGE = BLK_BASE[ADDR_W-1:WIN_OFF_W];
  localparam logic [PAGE_W-1:0] NBK_PAGE = NBK_BASE[ADDR_W-1:WIN_OFF_W];

  linkStrobe_t      strb;
  logic             enable, busy, retire;
  logic [TMO_W-1:0] tmoVal;

  die_link_ctrl #(
    .PAGE_W(PAGE_W), .TMO_W(TMO_W), .BLK_PAGE(BLK_PAGE), .NBK_PAGE(NBK_PAGE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel),
    .cpuPage(cpuAddr[ADDR_W-1:WIN_OFF_W]),
    .enable(enable), .tmoVal(tmoVal), .linkAck(linkAck),
    .cpuWait(cpuWait), .strb(strb), .busy(busy), .retire(retire)
  );

  die_link_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .LANE_W(LANE_W),
    .TMO_W(TMO_W), .REG_BASE(REG_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuWide(cpuWide),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .strb(strb), .busy(busy), .retire(retire),
    .enable(enable), .tmoVal(tmoVal),
    .linkReq(linkReq), .linkWr(linkWr), .linkWide(linkWide),
    .linkAddr(linkAddr), .linkWdata(linkWdata), .linkRdata(linkRdata),
    .linkDiv(linkDiv), .linkLanes(linkLanes)
  );

endmodule

// File: tb/die_link_initiator_tb.sv
module die_link_initiator_tb_top;

  localparam int CLK_P = 10;
  localparam int NOACK = 100000;
  localparam logic [15:0] REGB = 16'h0080;
  localparam logic [15:0] BLKB = 16'h0400;
  localparam logic [15:0] NBKB = 16'h0500;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuSel = 1'b0, cpuWe = 1'b0, cpuWide = 1'b0;
  logic [15:0] cpuAddr = '0, cpuWdata = '0;
  logic [15:0] cpuRdata;
  logic        cpuWait;
  logic        linkReq, linkWr, linkWide;
  logic [7:0]  linkAddr;
  logic [15:0] linkWdata;
  logic        linkAck = 1'b0;
  logic [15:0] linkRdata = '0;
  logic [3:0]  linkDiv;
  logic [1:0]  linkLanes;

  int nChecks = 0, nFail = 0;
  int ackDelay = 0;
  int tgtCnt = 0;
  logic served = 1'b0, prevReq = 1'b0;
  int reqStarts = 0;
  logic [7:0]  lastAddr = '0;
  logic [15:0] lastData = '0;
  logic        lastWide = 1'b0, lastWr = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  die_link_initiator dut_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuWide(cpuWide),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuWait(cpuWait),
    .linkReq(linkReq), .linkWr(linkWr), .linkWide(linkWide), .linkAddr(linkAddr),
    .linkWdata(linkWdata), .linkAck(linkAck), .linkRdata(linkRdata),
    .linkDiv(linkDiv), .linkLanes(linkLanes)
  );

  function automatic logic [7:0] memByte(input logic [7:0] a);
    return 8'(a * 8'd7 + 8'd3);
  endfunction

  // target answer; byte reads carry junk in the upper half
  function automatic logic [15:0] tgtData(input logic wide, input logic [7:0] a);
    return wide ? {memByte(a), memByte(8'(a + 8'd1))} : {8'hEE, memByte(a)};
  endfunction

  function automatic logic [15:0] expRead(input logic wide, input logic [7:0] a);
    return wide ? {memByte(a), memByte(8'(a + 8'd1))} : {8'h00, memByte(a)};
  endfunction

  // target model: acknowledge after ackDelay cycles of request
  always @(negedge clk) begin
    if (!rstN) begin
      linkAck <= 1'b0; tgtCnt <= 0; served <= 1'b0;
    end else if (linkReq && !served) begin
      if (tgtCnt >= ackDelay && ackDelay != NOACK) begin
        linkAck   <= 1'b1;
        linkRdata <= tgtData(linkWide, linkAddr);
        served    <= 1'b1;
        if (linkWr) begin
          lastWr <= 1'b1; lastAddr <= linkAddr; lastData <= linkWdata; lastWide <= linkWide;
        end
      end else begin
        tgtCnt <= tgtCnt + 1;
      end
    end else begin
      linkAck <= 1'b0;
      if (!linkReq) begin served <= 1'b0; tgtCnt <= 0; end
    end
  end

  always @(negedge clk) begin
    if (rstN && linkReq && !prevReq) reqStarts = reqStarts + 1;
    prevReq = linkReq;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cpuAccess(input logic we, input logic wide, input logic [15:0] addr,
                           input logic [15:0] wd, output logic [15:0] rd, output int waits);
    @(negedge clk);
    cpuSel = 1'b1; cpuWe = we; cpuWide = wide; cpuAddr = addr; cpuWdata = wd;
    waits = 0;
    #(CLK_P/4);
    while (cpuWait) begin
      waits++;
      @(negedge clk);
      #(CLK_P/4);
    end
    rd = cpuRdata;
    @(posedge clk);
    #1;
    cpuSel = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] off, input logic wide, output logic [15:0] rd);
    int w;
    cpuAccess(1'b0, wide, REGB + 16'(off), 16'h0, rd, w);
  endtask

  task automatic regWr(input logic [2:0] off, input logic wide, input logic [15:0] wd);
    int w;
    logic [15:0] rd;
    cpuAccess(1'b1, wide, REGB + 16'(off), wd, rd, w);
  endtask

  initial begin
    #(CLK_P * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int w, starts0;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(3'd0, 1'b1, rd); check("R1 ctl pair", rd, 16'h0000);
    regRd(3'd2, 1'b1, rd); check("R1 status", rd, 16'h0000);
    regRd(3'd4, 1'b1, rd); check("R1 addr buf", rd, 16'h0000);
    regRd(3'd6, 1'b1, rd); check("R1 data buf", rd, 16'h0000);
    check("R1 linkReq", linkReq, 0);
    check("R1 cpuWait", cpuWait, 0);

    // R2 disabled: window accesses ignored
    starts0 = reqStarts;
    cpuAccess(1'b1, 1'b1, BLKB + 16'h10, 16'h1234, rd, w);
    check("R2 no wait on write", w, 0);
    cpuAccess(1'b0, 1'b1, BLKB + 16'h10, 16'h0, rd, w);
    check("R2 read returns zero", rd, 16'h0000);
    repeat (5) @(negedge clk);
    check("R2 no request", reqStarts - starts0, 0);
    regRd(3'd4, 1'b1, rd); check("R2 addr buf untouched", rd, 16'h0000);

    // R3 byte setup in order: timeout first, then divider/lanes with enable
    regWr(3'd1, 1'b0, 16'h0014);
    regWr(3'd0, 1'b0, 16'h00A5);
    regRd(3'd0, 1'b1, rd); check("R3 ctl pair", rd, 16'hA514);
    regRd(3'd1, 1'b0, rd); check("R3 byte read", rd, 16'h0014);
    check("R3 linkDiv", linkDiv, 4'h5);
    check("R3 linkLanes", linkLanes, 2'h2);

    // R4 enable write-once
    regWr(3'd0, 1'b0, 16'h0000);
    regRd(3'd0, 1'b0, rd); check("R4 enable kept", rd, 16'h0080);

    // R3 wide write of the control pair
    regWr(3'd0, 1'b1, 16'h1314);
    regRd(3'd0, 1'b1, rd); check("R3 wide ctl write", rd, 16'h9314);

    // random phase: R5 R7 R8 R9 R12 R13
    for (int i = 0; i < 80; i++) begin
      logic we, wide, blk;
      logic [7:0]  off;
      logic [15:0] wd, expW;
      we   = 1'($urandom);
      wide = 1'($urandom);
      blk  = 1'($urandom);
      off  = 8'($urandom);
      wd   = 16'($urandom);
      ackDelay = int'($urandom % 5);
      expW = wide ? wd : {8'h00, wd[7:0]};
      lastWr = 1'b0;
      cpuAccess(we, wide, (blk ? BLKB : NBKB) + 16'(off), wd, rd, w);
      if (blk) begin
        if (!we) check("R7 blocking read data", rd, expRead(wide, off));
        else     check("R7 blocking write done", lastWr, 1);
      end else begin
        check("R8 nb no wait", w, 0);
        repeat (10) @(negedge clk);
        if (!we) begin
          regRd(3'd6, 1'b1, rd);
          check("R8 nb read in data buf", rd, expRead(wide, off));
        end
      end
      if (we) begin
        check("R5 link write addr", lastAddr, off);
        check("R9 link write data", lastData, expW);
        check("R9 link write width", lastWide, wide);
        regRd(3'd6, 1'b1, rd); check("R13 write data buf", rd, expW);
      end
      regRd(3'd4, 1'b1, rd);
      check("R12 addr buf", rd, {we, wide, 6'b0, off});
    end
    regRd(3'd2, 1'b0, rd); check("R10 no error yet", rd, 16'h0000);

    // R10 ack on the last timeout cycle counts as success (T=20)
    ackDelay = 20;
    cpuAccess(1'b0, 1'b1, BLKB + 16'h42, 16'h0, rd, w);
    check("R10 last-cycle ack data", rd, expRead(1'b1, 8'h42));
    check("R10 last-cycle ack waits", w, 22);
    regRd(3'd2, 1'b0, rd); check("R10 last-cycle ack no error", rd, 16'h0000);

    // R6 stall behind a pending non-blocking write
    ackDelay = 4;
    starts0 = reqStarts;
    cpuAccess(1'b1, 1'b1, NBKB + 16'h20, 16'hCAFE, rd, w);
    check("R6 first nb no wait", w, 0);
    cpuAccess(1'b0, 1'b0, BLKB + 16'h21, 16'h0, rd, w);
    check("R6 second stalled", (w > 6) ? 1 : 0, 1);
    check("R6 second data", rd, expRead(1'b0, 8'h21));
    check("R6 two requests", reqStarts - starts0, 2);
    check("R6 first write seen", lastData, 16'hCAFE);

    // R13 data buffer during a pending write, then timeout (R10)
    ackDelay = NOACK;
    cpuAccess(1'b1, 1'b1, NBKB + 16'h30, 16'hBEEF, rd, w);
    regRd(3'd6, 1'b1, rd); check("R13 buf while pending", rd, 16'hBEEF);
    regRd(3'd2, 1'b0, rd); check("R13 busy while pending", rd, 16'h0002);
    repeat (30) @(negedge clk);
    check("R10 request withdrawn", linkReq, 0);
    regRd(3'd2, 1'b0, rd); check("R10 error set", rd, 16'h0001);

    // R10 R11 blocking read timeout with T=5
    regWr(3'd1, 1'b0, 16'h0005);
    cpuAccess(1'b0, 1'b1, BLKB + 16'h55, 16'h0, rd, w);
    check("R10 timeout waits", w, 7);
    check("R11 timeout read zero", rd, 16'h0000);
    regRd(3'd6, 1'b1, rd); check("R11 data buf zero", rd, 16'h0000);

    // R10 error stays set after a later success
    ackDelay = 1;
    cpuAccess(1'b0, 1'b0, BLKB + 16'h07, 16'h0, rd, w);
    check("R7 read after timeout", rd, expRead(1'b0, 8'h07));
    regRd(3'd2, 1'b0, rd); check("R10 error sticky", rd, 16'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule